// File: doc/BRIEF.md
# Bit-Field Manipulation Unit

This combinational unit works on a contiguous group of bits, a field, inside one 32-bit data word. A field descriptor gives the position of the field's lowest bit and the field length. The descriptor comes either from two 5-bit inputs carried by the instruction or from a packed control word, so software can hold one descriptor in a register and reuse it. The unit can report on the field, force it to all zeros or all ones, or move it down to bit 0 as an unsigned or a signed value.

Every operation also returns two flags for the field as it stood in the input word. One flag shows that the field is all zeros. The other is a copy of the field's most significant bit. A field that would run past bit 31 is cut off at bit 31. Results and flags follow the inputs within the same cycle, and the unit holds no state.

Top module: `bitfield_unit`

## Requirements
- R1: When `desc_sel` is 1, the field position is read from `desc_word[4:0]` and the length code from `desc_word[9:5]`, and bits 31:10 of `desc_word` have no effect. When `desc_sel` is 0, `pos_imm` and `len_imm` are used and `desc_word` has no effect.
- R2: The position counts from bit 0, the least significant bit. Length code w selects a field of w+1 bits, so a position of 10 with code 4 covers bits 14 down to 10.
- R3: When position plus field length is more than 32, the field ends at bit 31.
- R4: Op code 0 (test) returns `data_in` unchanged in `data_out`.
- R5: Op code 1 (clear) zeroes the field bits and passes every other bit through unchanged.
- R6: Op code 2 (set) sets the field bits to one and passes every other bit through unchanged.
- R7: Op code 3 places the field at bit 0 of `data_out` and fills every bit above it with zero.
- R8: Op code 4 places the field at bit 0 of `data_out` and fills every bit above it with the field's top bit.
- R9: For every op code, `zero_flag` is 1 exactly when all field bits of `data_in` are zero.
- R10: For every op code, `sign_flag` equals the field's most significant bit in `data_in`, after any cut at bit 31.
- R11: Op codes 5, 6 and 7 behave as test: the data passes through unchanged and both flags are still produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_in | input | 32 | Word that holds the field |
| op | input | 3 | Operation code |
| desc_sel | input | 1 | 1 selects the packed descriptor, 0 selects the immediate inputs |
| pos_imm | input | 5 | Field position from the instruction |
| len_imm | input | 5 | Length code from the instruction (field length minus 1) |
| desc_word | input | 32 | Packed descriptor: position in [4:0], length code in [9:5] |
| data_out | output | 32 | Result word |
| zero_flag | output | 1 | Field of `data_in` is all zeros |
| sign_flag | output | 1 | Top bit of the field of `data_in` |

## Verification
The hardest cases to reach are the fields cut off at bit 31. A cut field appears only when a high position meets a long length code, and it is then easy to mistake a cut field for a full-length one in both the masks and the sign fill. The stimulus sweeps every position against every length code for every op code, using all-zero, all-one and mixed data words, so each cut and each edge appears with the field's top bit at both 0 and 1. A second sweep drives the packed descriptor with unrelated bits in its upper part and in the immediate inputs, to show which source is used.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
  parameter int unsigned DATA_W = 32;
  localparam int unsigned POS_W = $clog2(DATA_W);
  localparam int unsigned LEN_W = POS_W + 1;
  localparam int unsigned DESC_POS_LSB = 0;
  localparam int unsigned DESC_LEN_LSB = POS_W;

  typedef enum logic [2:0] {
    BF_TEST  = 3'd0,
    BF_CLEAR = 3'd1,
    BF_SET   = 3'd2,
    BF_EXTZ  = 3'd3,
    BF_EXTS  = 3'd4
  } bf_op_e;

  // Field length after the cut at the top of the word.
  function automatic logic [LEN_W-1:0] f_span(input logic [POS_W-1:0] pos,
                                              input logic [POS_W-1:0] lcode);
    logic [LEN_W-1:0] want;
    logic [LEN_W-1:0] room;
    want = {1'b0, lcode} + LEN_W'(1);
    room = LEN_W'(DATA_W) - {1'b0, pos};
    return (want < room) ? want : room;
  endfunction

  // Ones in the bits below the given count.
  function automatic logic [DATA_W-1:0] f_low_ones(input logic [LEN_W-1:0] n);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = (i < int'(n));
    return m;
  endfunction
endpackage

// File: rtl/bfu_desc_sel.sv
module bfu_desc_sel
  import bfu_pkg::*;
(
  input  logic              use_word,
  input  logic [POS_W-1:0]  pos_i,
  input  logic [POS_W-1:0]  lcode_i,
  input  logic [DATA_W-1:0] ctl_word,
  output logic [POS_W-1:0]  pos_o,
  output logic [POS_W-1:0]  lcode_o
);
  logic [POS_W-1:0] word_pos;
  logic [POS_W-1:0] word_lcode;

  assign word_pos   = ctl_word[DESC_POS_LSB +: POS_W];
  assign word_lcode = ctl_word[DESC_LEN_LSB +: POS_W];

  always_comb begin
    if (use_word) begin
      pos_o   = word_pos;
      lcode_o = word_lcode;
    end else begin
      pos_o   = pos_i;
      lcode_o = lcode_i;
    end
  end
endmodule

// File: rtl/bfu_mask_gen.sv
module bfu_mask_gen
  import bfu_pkg::*;
(
  input  logic [POS_W-1:0]  pos,
  input  logic [POS_W-1:0]  lcode,
  output logic [LEN_W-1:0]  span,
  output logic [DATA_W-1:0] mask,
  output logic [POS_W-1:0]  top_idx
);
  logic [LEN_W:0] top_sum;

  assign span = f_span(pos, lcode);

  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_bit
    assign mask[gi] = (gi >= int'(pos)) && (gi < int'(pos) + int'(span));
  end

  assign top_sum = {2'b00, pos} + {1'b0, span} - (LEN_W+1)'(1);
  assign top_idx = top_sum[POS_W-1:0];
endmodule

// File: rtl/bfu_field_ops.sv
module bfu_field_ops
  import bfu_pkg::*;
(
  input  logic [DATA_W-1:0] src,
  input  logic [2:0]        op,
  input  logic [POS_W-1:0]  pos,
  input  logic [LEN_W-1:0]  span,
  input  logic [DATA_W-1:0] mask,
  input  logic [POS_W-1:0]  top_idx,
  output logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] field_val,
  output logic              zf,
  output logic              sf
);
  logic [DATA_W-1:0] upper_fill;

  assign field_val  = (src & mask) >> pos;
  assign zf         = (field_val == '0);
  assign sf         = src[top_idx];
  assign upper_fill = sf ? ~f_low_ones(span) : '0;

  always_comb begin
    unique case (op)
      BF_CLEAR: result = src & ~mask;
      BF_SET:   result = src | mask;
      BF_EXTZ:  result = field_val;
      BF_EXTS:  result = field_val | upper_fill;
      default:  result = src;
    endcase
  end
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
  import bfu_pkg::*;
(
  input  logic [31:0] data_in,
  input  logic [2:0]  op,
  input  logic        desc_sel,
  input  logic [4:0]  pos_imm,
  input  logic [4:0]  len_imm,
  input  logic [31:0] desc_word,
  output logic [31:0] data_out,
  output logic        zero_flag,
  output logic        sign_flag
);
  logic [POS_W-1:0]  sel_pos;
  logic [POS_W-1:0]  sel_lcode;
  logic [LEN_W-1:0]  span;
  logic [DATA_W-1:0] field_mask;
  logic [POS_W-1:0]  top_idx;
  logic [DATA_W-1:0] field_val;

  bfu_desc_sel u_sel (
    .use_word (desc_sel),
    .pos_i    (pos_imm),
    .lcode_i  (len_imm),
    .ctl_word (desc_word),
    .pos_o    (sel_pos),
    .lcode_o  (sel_lcode)
  );

  bfu_mask_gen u_mask (
    .pos     (sel_pos),
    .lcode   (sel_lcode),
    .span    (span),
    .mask    (field_mask),
    .top_idx (top_idx)
  );

  bfu_field_ops u_ops (
    .src       (data_in),
    .op        (op),
    .pos       (sel_pos),
    .span      (span),
    .mask      (field_mask),
    .top_idx   (top_idx),
    .result    (data_out),
    .field_val (field_val),
    .zf        (zero_flag),
    .sf        (sign_flag)
  );
endmodule

// File: rtl/bfu_checker.sv
module bfu_checker
  import bfu_pkg::*;
(
  input logic [31:0]       data_in,
  input logic [2:0]        op,
  input logic [31:0]       data_out,
  input logic              zero_flag,
  input logic              sign_flag,
  input logic [POS_W-1:0]  sel_pos,
  input logic [DATA_W-1:0] field_mask,
  input logic [POS_W-1:0]  top_idx
);
  always_comb begin
    if (!$isunknown({data_in, op, sel_pos, field_mask, top_idx})) begin
      assert_mask_cut_R3: assert (field_mask != '0 && field_mask[top_idx]
                                  && $countones(field_mask) <= DATA_W - int'(sel_pos));
      if (op == 3'd0) assert_test_pass_R4: assert (data_out == data_in);
      if (op == 3'd1) assert_clear_R5: assert ((data_out & field_mask) == '0
                                  && (data_out & ~field_mask) == (data_in & ~field_mask));
      if (op == 3'd2) assert_set_R6: assert ((data_out & field_mask) == field_mask
                                  && (data_out & ~field_mask) == (data_in & ~field_mask));
      if (op == 3'd3) assert_extz_R7: assert ((data_out >> $countones(field_mask)) == '0);
      if (op == 3'd4) assert_exts_R8: assert (data_out[DATA_W-1] == sign_flag);
      assert_zero_flag_R9: assert (zero_flag == ((data_in & field_mask) == '0));
      assert_sign_flag_R10: assert (!(sign_flag && zero_flag));
      if (op > 3'd4) assert_spare_op_R11: assert (data_out == data_in);
    end
  end
endmodule

bind bitfield_unit bfu_checker u_chk (
  .data_in    (data_in),
  .op         (op),
  .data_out   (data_out),
  .zero_flag  (zero_flag),
  .sign_flag  (sign_flag),
  .sel_pos    (sel_pos),
  .field_mask (field_mask),
  .top_idx    (top_idx)
);

// File: tb/bitfield_unit_tb.sv
`timescale 1ns/1ps
module bitfield_unit_tb;
  logic        clk = 1'b0;
  logic [31:0] data_in = '0;
  logic [2:0]  op = '0;
  logic        desc_sel = 1'b0;
  logic [4:0]  pos_imm = '0;
  logic [4:0]  len_imm = '0;
  logic [31:0] desc_word = '0;
  logic [31:0] data_out;
  logic        zero_flag;
  logic        sign_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bitfield_unit u_dut (
    .data_in   (data_in),
    .op        (op),
    .desc_sel  (desc_sel),
    .pos_imm   (pos_imm),
    .len_imm   (len_imm),
    .desc_word (desc_word),
    .data_out  (data_out),
    .zero_flag (zero_flag),
    .sign_flag (sign_flag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h (op=%0d sel=%0b pos=%0d len=%0d desc=%h din=%h)",
               req, act, exp, op, desc_sel, pos_imm, len_imm, desc_word, data_in);
    end
  endtask

  // Independent bit-by-bit model of the requirements.
  task automatic model(input logic [31:0] s, input int opc, input int pos, input int lc,
                       output logic [31:0] r, output logic z, output logic sg);
    int last;
    logic [31:0] fm;
    logic [31:0] fv;
    last = pos + lc;
    if (last > 31) last = 31;
    fm = '0;
    fv = '0;
    for (int i = pos; i <= last; i++) fm[i] = 1'b1;
    for (int j = 0; j <= last - pos; j++) fv[j] = s[pos + j];
    z = ((s & fm) == 32'd0);
    sg = s[last];
    case (opc)
      1: r = s & ~fm;
      2: r = s | fm;
      3: r = fv;
      4: begin
        r = fv;
        for (int j = last - pos + 1; j < 32; j++) r[j] = sg;
      end
      default: r = s;
    endcase
  endtask

  function automatic string op_req(input int opc);
    case (opc)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      3: return "R7";
      4: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic apply(input logic [31:0] s, input int opc, input bit sel,
                       input int ip, input int il, input logic [31:0] dw, input string req);
    logic [31:0] er;
    logic ez, es;
    int ep, el;
    @(negedge clk);
    data_in = s; op = 3'(opc); desc_sel = sel;
    pos_imm = 5'(ip); len_imm = 5'(il); desc_word = dw;
    #1;
    ep = sel ? int'(dw[4:0]) : ip;
    el = sel ? int'(dw[9:5]) : il;
    model(s, opc, ep, el, er, ez, es);
    check(req.len() > 0 ? req : op_req(opc), data_out, er);
    check("R9", {31'd0, zero_flag}, {31'd0, ez});
    check("R10", {31'd0, sign_flag}, {31'd0, es});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [3];
    pats[0] = 32'h0000_0000;
    pats[1] = 32'hFFFF_FFFF;
    pats[2] = 32'hA5C3_1E97;

    // Idle state: all-zero inputs, test on a 1-bit field at bit 0
    apply(32'd0, 0, 1'b0, 0, 0, 32'd0, "R4");

    // R2 directed: position 10, code 4 covers bits 14..10
    apply(32'd0, 2, 1'b0, 10, 4, 32'd0, "R2");
    check("R2", data_out, 32'h0000_7C00);
    apply(32'hFFFF_FFFF, 3, 1'b0, 10, 4, 32'd0, "R2");
    check("R2", data_out, 32'h0000_001F);

    // R3 directed: position 28, code 7 cut to bits 31..28
    apply(32'hFFFF_FFFF, 3, 1'b0, 28, 7, 32'd0, "R3");
    check("R3", data_out, 32'h0000_000F);
    apply(32'hF000_0000, 4, 1'b0, 28, 7, 32'd0, "R3");
    check("R3", data_out, 32'hFFFF_FFFF);
    apply(32'h8000_0000, 4, 1'b0, 31, 31, 32'd0, "R3");
    check("R3", data_out, 32'hFFFF_FFFF);
    // R8 with a full-width field
    apply(32'h8000_0001, 4, 1'b0, 0, 31, 32'd0, "R8");

    // Full sweep of positions, length codes, op codes and data patterns
    for (int p = 0; p < 3; p++)
      for (int o = 0; o < 8; o++)
        for (int ps = 0; ps < 32; ps++)
          for (int lc = 0; lc < 32; lc++)
            apply(pats[p], o, 1'b0, ps, lc, 32'hDEAD_BEEF, "");

    // R1: descriptor word with unrelated upper bits; immediates hold other values
    for (int ps = 0; ps < 32; ps++)
      for (int lc = 0; lc < 32; lc++)
        apply(32'hC3A5_5A3C, (ps + lc) % 5, 1'b1, 31 - ps, (lc + 7) % 32,
              {22'h2A_B5C3 ^ 22'(ps * 97 + lc), 5'(lc), 5'(ps)}, "R1");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule